// File: doc/BRIEF.md
# Display Controller Control and Status Unit

This unit holds the control word of a raster display controller and keeps its event status. Software reaches it through a flat register port: one write strobe, one address shared by reads and writes, and a read value that follows the address in the same cycle. The control word carries the run enable, the panel type, the load mode and five interrupt enables. The timing and fetch logic report events as one-cycle pulses. The unit latches each pulse into a sticky status bit, clears each bit by that bit's own rule, and drives one interrupt line.

Stopping is graceful. When software writes the enable bit to zero, scanning carries on until the timing logic signals the end of the current frame. Only then does `scanActive` fall and the frame-done status rise. Writing the enable bit back to one during that wind-down cancels it. The error indications (FIFO underflow, lost sync) always reach the interrupt line, whatever the enables say.

Top module: `lcdCtrlStatus`

## Requirements
- R1: After reset, both registers read zero, and `scanActive`, `panelTft`, `loadMode` and `irq` are all low.
- R2: The control register sits at address 0 and keeps only these fields: bit 0 enable, bit 2 vsync interrupt enable, bit 3 done enable, bit 4 palette enable, bit 5 inverted-line enable, bit 6 line enable, bit 7 TFT panel, bits 21:20 load mode (0 palette and frame, 1 palette only, 2 frame only). All other bits read as zero. `panelTft` and `loadMode` follow the stored fields.
- R3: The status register sits at address 1: bit 0 done, 1 vsync, 2 sync lost, 3 AC-bias count, 4 line, 5 FIFO underflow, 6 palette loaded. An event pulse sets its bit on the following clock edge, but only while `scanActive` is high. Pulses that arrive while idle are ignored.
- R4: Writing enable=1 while idle raises `scanActive` one edge later. Writing enable=0 while scanning keeps `scanActive` high until a `frameEnd` pulse; it drops on the edge that samples that pulse.
- R5: The done bit is set on the edge that ends the wind-down. Status writes cannot clear it. It clears only when enable=1 is written while idle.
- R6: Writing 1 to the vsync, AC-bias or line status bit clears it. Writing 0 leaves it set. An event that arrives in the same cycle as its clear wins.
- R7: Sync-lost and underflow clear when enable=0 is written while scanning. Status writes have no effect on them.
- R8: Palette loaded clears on a status write of 1 only while the load mode is 1. In every load mode it clears when enable=0 is written while scanning.
- R9: `irq` is high when any of these holds: done with its enable, vsync with its enable, palette with its enable, line set with the line enable, line clear with the inverted-line enable, sync lost, or underflow. The AC-bias bit never raises `irq`.
- R10: Writing enable=1 during the wind-down, even in the same cycle as `frameEnd`, returns the unit to scanning without setting done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Register address for both reads and writes |
| regWe | input | 1 | Write strobe |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Value of the addressed register, available in the same cycle |
| evVsync | input | 1 | Vertical sync event pulse |
| evSyncLost | input | 1 | Sync-lost event pulse |
| evAcBias | input | 1 | AC-bias count event pulse |
| evLine | input | 1 | Line-match event pulse |
| evUnderflow | input | 1 | FIFO underflow event pulse |
| evPalette | input | 1 | Palette-loaded event pulse |
| frameEnd | input | 1 | End-of-frame pulse from the timing logic |
| scanActive | output | 1 | High while the controller scans, including the wind-down |
| panelTft | output | 1 | Panel type field |
| loadMode | output | 2 | Load mode field |
| irq | output | 1 | Combined interrupt |

## Verification
If the sequencer is left in the wrong state, `scanActive` shows it on the edge after the offending write or `frameEnd`. The done bit then rises too early, too late or not at all, and it can be read one cycle later. If a status bit is mis-kept, it shows on the next read of address 1. Because `irq` is a direct combination of the stored bits, it shows the fault in the same cycle. A wrong clear rule only shows up when the matching clear stimulus arrives: a status write, a disable or a re-enable. The bench therefore reads the status straight after each of these stimuli, and sweeps every enable pattern against each maskable event.

// File: rtl/lcdCtrlPkg.sv
package lcdCtrlPkg;
  // control field positions (decoded by software)
  localparam int EN_BIT   = 0;
  localparam int IE_LO    = 2;
  localparam int IE_W     = 5;
  localparam int IE_VSYNC = 2;
  localparam int IE_DONE  = 3;
  localparam int IE_PAL   = 4;
  localparam int IE_LINEN = 5;
  localparam int IE_LINE  = 6;
  localparam int TFT_BIT  = 7;
  localparam int LM_LO    = 20;
  localparam int LM_W     = 2;
  localparam logic [LM_W-1:0] LM_PALETTE_ONLY = 2'd1;

  // status bit positions
  localparam int ST_DONE  = 0;
  localparam int ST_VSYNC = 1;
  localparam int ST_SYNCL = 2;
  localparam int ST_ACB   = 3;
  localparam int ST_LINE  = 4;
  localparam int ST_UFL   = 5;
  localparam int ST_PAL   = 6;
  localparam int ST_W     = 7;

  typedef enum logic [1:0] {SeqIdle = 2'd0, SeqRun = 2'd1, SeqDrain = 2'd2} seqState_t;

  typedef struct packed {
    logic active;      // scanning, including the wind-down
    logic reEnable;    // idle -> run transition this cycle
    logic disableClr;  // run -> drain transition this cycle
    logic doneSet;     // drain -> idle transition this cycle
  } seqStrobe_t;
endpackage

// File: rtl/lcdSeq.sv
module lcdSeq
  import lcdCtrlPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWr,
  input  logic       enReq,
  input  logic       frameEnd,
  output seqStrobe_t strobe
);
  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe = '0;
    strobe.active = (state != SeqIdle);
    unique case (state)
      SeqIdle: if (ctrlWr && enReq) begin
        stateNext = SeqRun;
        strobe.reEnable = 1'b1;
      end
      SeqRun: if (ctrlWr && !enReq) begin
        stateNext = SeqDrain;
        strobe.disableClr = 1'b1;
      end
      SeqDrain: begin
        if (ctrlWr && enReq) begin
          stateNext = SeqRun;
        end else if (frameEnd) begin
          stateNext = SeqIdle;
          strobe.doneSet = 1'b1;
        end
      end
      default: stateNext = SeqIdle;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SeqIdle;
    else       state <= stateNext;
  end

  // R4: a disable write while running keeps scanning alive
  a_r4_drain_active: assert property (@(posedge clk) disable iff (!rstN)
    (state == SeqRun && ctrlWr && !enReq) |=> strobe.active);

  // R10: re-enable during the wind-down returns to running
  a_r10_cancel_drain: assert property (@(posedge clk) disable iff (!rstN)
    (state == SeqDrain && ctrlWr && enReq) |=> (state == SeqRun));
endmodule

// File: rtl/lcdRegs.sv
module lcdRegs
  import lcdCtrlPkg::*;
#(
  parameter int DATA_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic              stsWr,
  input  logic              selCtrl,
  input  logic              selSts,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [ST_W-1:1]   evVec,
  input  seqStrobe_t        strobe,
  output logic [DATA_W-1:0] regRdata,
  output logic              panelTft,
  output logic [LM_W-1:0]   loadMode,
  output logic              irq
);
  localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'(
      (1 << EN_BIT) | (((1 << IE_W) - 1) << IE_LO) | (1 << TFT_BIT) |
      (((1 << LM_W) - 1) << LM_LO));

  logic [DATA_W-1:0] ctrlReg;
  logic [ST_W-1:0]   status, setVec, clrVec;

  always_ff @(posedge clk) begin
    if (!rstN)       ctrlReg <= '0;
    else if (ctrlWr) ctrlReg <= regWdata & CTRL_MASK;
  end

  assign loadMode = ctrlReg[LM_LO +: LM_W];
  assign panelTft = ctrlReg[TFT_BIT];

  always_comb begin
    setVec = {evVec & {(ST_W-1){strobe.active}}, strobe.doneSet};
    clrVec = '0;
    clrVec[ST_DONE]  = strobe.reEnable;
    clrVec[ST_VSYNC] = stsWr && regWdata[ST_VSYNC];
    clrVec[ST_ACB]   = stsWr && regWdata[ST_ACB];
    clrVec[ST_LINE]  = stsWr && regWdata[ST_LINE];
    clrVec[ST_SYNCL] = strobe.disableClr;
    clrVec[ST_UFL]   = strobe.disableClr;
    clrVec[ST_PAL]   = strobe.disableClr ||
                       (stsWr && regWdata[ST_PAL] && loadMode == LM_PALETTE_ONLY);
  end

  always_ff @(posedge clk) begin
    if (!rstN) status <= '0;
    else       status <= setVec | (status & ~clrVec);
  end

  always_comb begin
    irq = (status[ST_DONE]  && ctrlReg[IE_DONE])  ||
          (status[ST_VSYNC] && ctrlReg[IE_VSYNC]) ||
          (status[ST_PAL]   && ctrlReg[IE_PAL])   ||
          (status[ST_LINE]  && ctrlReg[IE_LINE])  ||
          (!status[ST_LINE] && ctrlReg[IE_LINEN]) ||
          status[ST_SYNCL] || status[ST_UFL];
  end

  always_comb begin
    regRdata = '0;
    if (selCtrl)     regRdata = ctrlReg;
    else if (selSts) regRdata = DATA_W'(status);
  end

  // R3: while idle, only status writes may alter the event bits
  a_r3_idle_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.active && !stsWr) |=> $stable(status[ST_W-1:1]));

  // R5: done holds until re-enable
  a_r5_done_holds: assert property (@(posedge clk) disable iff (!rstN)
    (status[ST_DONE] && !strobe.reEnable) |=> status[ST_DONE]);

  // R7: disable clears sync lost unless a new one arrives
  a_r7_synclost_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.disableClr && !evVec[ST_SYNCL]) |=> !status[ST_SYNCL]);

  // R8: outside palette-only mode a status write keeps palette loaded
  a_r8_palette_kept: assert property (@(posedge clk) disable iff (!rstN)
    (stsWr && loadMode != LM_PALETTE_ONLY && !strobe.disableClr && status[ST_PAL])
      |=> status[ST_PAL]);

  // R9: error bits always reach the interrupt
  a_r9_errors_reported: assert property (@(posedge clk) disable iff (!rstN)
    (status[ST_SYNCL] || status[ST_UFL]) |-> irq);
endmodule

// File: rtl/lcdCtrlStatus.sv
module lcdCtrlStatus
  import lcdCtrlPkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              evVsync,
  input  logic              evSyncLost,
  input  logic              evAcBias,
  input  logic              evLine,
  input  logic              evUnderflow,
  input  logic              evPalette,
  input  logic              frameEnd,
  output logic              scanActive,
  output logic              panelTft,
  output logic [1:0]        loadMode,
  output logic              irq
);
  logic selCtrl, selSts, ctrlWr, stsWr;
  logic [ST_W-1:1] evVec;
  seqStrobe_t strobe;

  always_comb begin
    selCtrl = (regAddr == ADDR_W'(CTRL_ADDR));
    selSts  = (regAddr == ADDR_W'(STAT_ADDR));
    ctrlWr  = regWe && selCtrl;
    stsWr   = regWe && selSts;
    evVec   = '0;
    evVec[ST_VSYNC] = evVsync;
    evVec[ST_SYNCL] = evSyncLost;
    evVec[ST_ACB]   = evAcBias;
    evVec[ST_LINE]  = evLine;
    evVec[ST_UFL]   = evUnderflow;
    evVec[ST_PAL]   = evPalette;
  end

  lcdSeq u_seq (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .enReq(regWdata[EN_BIT]),
    .frameEnd(frameEnd), .strobe(strobe)
  );

  lcdRegs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .stsWr(stsWr),
    .selCtrl(selCtrl), .selSts(selSts), .regWdata(regWdata), .evVec(evVec),
    .strobe(strobe), .regRdata(regRdata), .panelTft(panelTft),
    .loadMode(loadMode), .irq(irq)
  );

  assign scanActive = strobe.active;
endmodule

// File: tb/test_lcdCtrlStatus.sv
module test_lcdCtrlStatus;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] regAddr = '0;
  logic regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic evVsync = 0, evSyncLost = 0, evAcBias = 0, evLine = 0, evUnderflow = 0, evPalette = 0;
  logic frameEnd = 0;
  logic scanActive, panelTft, irq;
  logic [1:0] loadMode;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  lcdCtrlStatus i_lcdCtrlStatus (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .evVsync(evVsync), .evSyncLost(evSyncLost), .evAcBias(evAcBias),
    .evLine(evLine), .evUnderflow(evUnderflow), .evPalette(evPalette), .frameEnd(frameEnd),
    .scanActive(scanActive), .panelTft(panelTft), .loadMode(loadMode), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWe = 1'b1; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdReg(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic setEv(input int idx, input logic v);
    case (idx)
      1: evVsync = v;
      2: evSyncLost = v;
      3: evAcBias = v;
      4: evLine = v;
      5: evUnderflow = v;
      6: evPalette = v;
      7: frameEnd = v;
      default: ;
    endcase
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    setEv(idx, 1'b1);
    @(negedge clk);
    setEv(idx, 1'b0);
  endtask

  function automatic logic expIrq(input logic [6:0] st, input logic [4:0] m);
    return (st[0] & m[1]) | (st[1] & m[0]) | (st[6] & m[2]) | (st[4] & m[4]) |
           (~st[4] & m[3]) | st[2] | st[5];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int evList [4] = '{1, 3, 4, 6};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rdReg(0, rd); chk("R1 ctrl", rd, 0);
    rdReg(1, rd); chk("R1 status", rd, 0);
    chk("R1 outputs", {scanActive, panelTft, loadMode, irq}, 0);

    // R3 events ignored while idle
    pulse(1); pulse(5);
    rdReg(1, rd); chk("R3 idle ignore", rd, 0);

    // R2 field storage, R4 start
    wrReg(0, 32'hFFFF_FFFF);
    rdReg(0, rd); chk("R2 ctrl mask", rd, 32'h0030_00FD);
    chk("R2 tft/mode", {panelTft, loadMode}, 3'b111);
    chk("R4 started", scanActive, 1);
    wrReg(0, 32'h1);
    chk("R2 tft off", panelTft, 0);

    // R3/R9/R6/R8 sweep over every enable pattern
    foreach (evList[k]) begin
      pulse(evList[k]);
      rdReg(1, rd); chk("R3 event set", rd, 32'(1) << evList[k]);
      for (int m = 0; m < 32; m++) begin
        wrReg(0, 32'h1 | (32'(m) << 2) | (32'h1 << 20));
        chk($sformatf("R9 irq ev%0d m%0d", evList[k], m), irq,
            expIrq(7'(1 << evList[k]), 5'(m)));
      end
      wrReg(1, 32'(1) << evList[k]);
      rdReg(1, rd); chk("R6 R8 write-one clear", rd, 0);
    end

    // R6 writing zero keeps; set wins over clear
    wrReg(0, 32'h1);
    pulse(1);
    wrReg(1, 0);
    rdReg(1, rd); chk("R6 zero write keeps", rd, 32'h2);
    @(negedge clk);
    regAddr = 1; regWe = 1; regWdata = 32'h2; evVsync = 1;
    @(negedge clk);
    regWe = 0; evVsync = 0;
    rdReg(1, rd); chk("R6 set wins", rd, 32'h2);
    wrReg(1, 32'h2);

    // R8 palette write ignored in load mode 0
    pulse(6);
    wrReg(1, 32'h40);
    rdReg(1, rd); chk("R8 mode0 keeps", rd, 32'h40);

    // R7 errors
    pulse(5); pulse(2);
    rdReg(1, rd); chk("R7 errors set", rd, 32'h64);
    chk("R9 errors irq", irq, 1);
    wrReg(1, 32'h24);
    rdReg(1, rd); chk("R7 write ignored", rd, 32'h64);

    // disable: R4 drain, R7/R8 cleared
    wrReg(0, 0);
    chk("R4 draining", scanActive, 1);
    rdReg(1, rd); chk("R7 R8 disable clears", rd, 0);
    pulse(1);
    rdReg(1, rd); chk("R3 drain captures", rd, 32'h2);
    wrReg(1, 32'h2);
    pulse(7);
    chk("R4 stopped", scanActive, 0);
    rdReg(1, rd); chk("R5 done set", rd, 32'h1);
    wrReg(0, 32'h8);
    chk("R9 done irq", irq, 1);
    wrReg(1, 32'h1);
    rdReg(1, rd); chk("R5 write cannot clear", rd, 32'h1);
    wrReg(0, 32'h1);
    rdReg(1, rd); chk("R5 re-enable clears", rd, 0);
    chk("R4 restarted", scanActive, 1);

    // R10 cancel during drain
    wrReg(0, 0);
    wrReg(0, 32'h1);
    pulse(7);
    chk("R10 still active", scanActive, 1);
    rdReg(1, rd); chk("R10 no done", rd, 0);
    wrReg(0, 0);
    @(negedge clk);
    regAddr = 0; regWe = 1; regWdata = 32'h1; frameEnd = 1;
    @(negedge clk);
    regWe = 0; frameEnd = 0;
    chk("R10 same-cycle active", scanActive, 1);
    rdReg(1, rd); chk("R10 same-cycle no done", rd, 0);
    wrReg(0, 0);
    pulse(7);
    chk("R4 final stop", scanActive, 0);
    rdReg(1, rd); chk("R5 final done", rd, 32'h1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule